// File: doc/BRIEF.md
# Touch Key Rollover Limiter

The limiter sits between a per-key touch detector and the key outputs of a small capacitive keypad. It takes one raw detect flag per key and drives one registered, active-high output per key. The number of outputs that may be high together is capped at one or two by a single option input, and the cap applies to every key in the same way.

Outputs are handed out by arrival. A key that already holds an output keeps it for as long as its raw flag stays high. A key that becomes active while every slot is taken is held back. It takes a slot at the first clock edge at which a slot is free and its raw flag is still high.

When several keys compete for the free slots at the same edge, the lower key index wins. When the cap drops while more keys hold outputs than the new cap allows, the lowest-index holders keep their outputs.

Top module: `key_rollover_limiter`

## Requirements
- R1: While rst_ni is low, every bit of key_o is 0, whatever raw_i shows.
- R2: key_o changes only at a rising clock edge and reflects raw_i and dual_i as sampled at that edge. A key whose raw flag is 0 at an edge has its output at 0 after that edge.
- R3: With dual_i = 1, at most two bits of key_o are 1 at any time.
- R4: With dual_i = 0 at an edge, at most one bit of key_o is 1 after that edge.
- R5: A key whose output is 1 keeps it at the next edge while its raw flag stays 1, provided the number of held keys does not exceed the cap. Newly active keys with lower indices do not displace it.
- R6: A key that is raw-active but refused for lack of a slot stays 0. It receives a slot at the same edge at which a holder's release is sampled, provided its raw flag is still 1.
- R7: If more raw-active, unheld keys compete than there are free slots, the slots go to the lowest bit indices of raw_i first (bit 0 highest priority).
- R8: If dual_i falls while two keys hold outputs and both stay raw-active, only the holder with the lower bit index keeps its output after the edge.
- R9: If any raw flag is 1 at an edge, at least one bit of key_o is 1 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raw_i | input | NUM_KEYS | Raw per-key detect flags, bit k is key k |
| dual_i | input | 1 | Cap select: 1 allows two outputs, 0 allows one |
| key_o | output | NUM_KEYS | Registered active-high key outputs, bit k is key k |

## Verification
The only state is the set of granted keys, and that set is key_o itself. A wrong grant therefore shows at the ports after one clock. It appears as an output that is high without a raw flag, as too many outputs high, or as a holder that disappears. It can also appear as a waiting key that misses the edge at which it should have taken a freed slot.

A mistake in tie-break order or in trimming shows only when certain input patterns are applied in sequence. For that reason, every pair of consecutive raw patterns is swept under both cap settings.

// File: rtl/key_roll_pkg.sv
package key_roll_pkg;
  parameter int unsigned DEF_KEYS   = 4;
  parameter int unsigned DEF_WIDE   = 2;
  parameter int unsigned DEF_NARROW = 1;
endpackage

// File: rtl/key_roll_popcount.sv
module key_roll_popcount #(
  parameter int unsigned N  = 4,
  parameter int unsigned CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < N; i++) cnt_o = cnt_o + CW'(vec_i[i]);
  end
endmodule

// File: rtl/key_roll_pick.sv
// Grants up to room_i of the candidates, lowest index first.
module key_roll_pick #(
  parameter int unsigned N  = 4,
  parameter int unsigned CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  cand_i,
  input  logic [CW-1:0] room_i,
  output logic [N-1:0]  grant_o
);
  logic [CW-1:0] used;
  always_comb begin
    used    = '0;
    grant_o = '0;
    for (int i = 0; i < N; i++) begin
      if (cand_i[i] && (used < room_i)) begin
        grant_o[i] = 1'b1;
        used       = used + CW'(1);
      end
    end
  end
endmodule

// File: rtl/key_rollover_limiter.sv
module key_rollover_limiter
  import key_roll_pkg::*;
#(
  parameter int unsigned NUM_KEYS   = DEF_KEYS,
  parameter int unsigned WIDE_CAP   = DEF_WIDE,
  parameter int unsigned NARROW_CAP = DEF_NARROW
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_KEYS-1:0] raw_i,
  input  logic                dual_i,
  output logic [NUM_KEYS-1:0] key_o
);
  localparam int unsigned CW = $clog2(NUM_KEYS + 1);

  logic [CW-1:0]       cap, kept_cnt, room;
  logic [NUM_KEYS-1:0] still_held, kept, fresh, nxt;

  assign cap        = dual_i ? CW'(WIDE_CAP) : CW'(NARROW_CAP);
  assign still_held = key_o & raw_i;

  // holders first; trimmed to the cap when the cap shrinks
  key_roll_pick #(.N(NUM_KEYS), .CW(CW)) u_keep (
    .cand_i (still_held),
    .room_i (cap),
    .grant_o(kept)
  );

  key_roll_popcount #(.N(NUM_KEYS), .CW(CW)) u_cnt (
    .vec_i(kept),
    .cnt_o(kept_cnt)
  );

  assign room = cap - kept_cnt;

  key_roll_pick #(.N(NUM_KEYS), .CW(CW)) u_new (
    .cand_i (raw_i & ~kept),
    .room_i (room),
    .grant_o(fresh)
  );

  assign nxt = kept | fresh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) key_o <= '0;
    else         key_o <= nxt;
  end

  // R1
  always_comb begin
    if (!rst_ni) a_r1_reset_clear: assert (key_o == '0);
  end

  a_r3_wide_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(key_o) <= WIDE_CAP);

  a_r4_narrow_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dual_i |=> ($countones(key_o) <= NARROW_CAP));

  a_r9_some_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|raw_i) |=> (|key_o));

  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key_chk
    a_r2_needs_raw: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !raw_i[k] |=> !key_o[k]);
    a_r5_holder_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (key_o[k] && raw_i[k] && dual_i) |=> key_o[k]);
  end
endmodule

// File: tb/key_rollover_limiter_test.sv
`timescale 1ns/1ps
module key_rollover_limiter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] raw = '0;
  logic       dual = 1'b1;
  logic [3:0] key;
  logic [3:0] model = '0;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  key_rollover_limiter uut (
    .clk_i(clk), .rst_ni(rst_n), .raw_i(raw), .dual_i(dual), .key_o(key)
  );

  function automatic logic [3:0] ref_next(logic [3:0] held, logic [3:0] r, logic d);
    int lim = d ? 2 : 1;
    int n = 0;
    logic [3:0] res = '0;
    for (int i = 0; i < 4; i++)
      if (held[i] && r[i] && n < lim) begin res[i] = 1'b1; n++; end
    for (int i = 0; i < 4; i++)
      if (r[i] && !res[i] && n < lim) begin res[i] = 1'b1; n++; end
    return res;
  endfunction

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: key_o=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(logic [3:0] r, logic d);
    @(negedge clk);
    raw  = r;
    dual = d;
    @(posedge clk);
    #1;
    model = ref_next(model, r, d);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: key_o=%b expected run end", key);
    finish_run();
  end

  initial begin
    raw = 4'hF;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", key, 4'b0000);
    @(negedge clk);
    raw = '0;
    rst_n = 1'b1;
    model = '0;

    // R2: registered update
    step(4'b0001, 1'b1);
    check("R2 grant", key, 4'b0001);
    @(negedge clk);
    raw = 4'b0010;
    #1;
    check("R2 before edge", key, 4'b0001);
    step(4'b0010, 1'b1);
    check("R2 after edge", key, 4'b0010);
    step(4'b0000, 1'b1);
    check("R2 release", key, 4'b0000);

    // R7: simultaneous arrivals, lowest index first
    step(4'b1111, 1'b1);
    check("R7 wide tie", key, 4'b0011);
    step(4'b0000, 1'b0);
    step(4'b1110, 1'b0);
    check("R7 narrow tie", key, 4'b0010);
    step(4'b0000, 1'b1);

    // R5: holder survives lower-index arrivals
    step(4'b1000, 1'b1);
    step(4'b1111, 1'b1);
    check("R5 holder kept", key, 4'b1001);
    step(4'b1111, 1'b1);
    check("R5 stable", key, 4'b1001);

    // R6: waiting key takes the freed slot at once
    step(4'b0000, 1'b1);
    step(4'b0001, 1'b1);
    step(4'b0011, 1'b1);
    step(4'b0111, 1'b1);
    check("R6 suppressed", key, 4'b0011);
    step(4'b0110, 1'b1);
    check("R6 slot taken", key, 4'b0110);

    // R8: cap drops with two holders
    step(4'b0110, 1'b0);
    check("R8 trim", key, 4'b0010);
    step(4'b0110, 1'b1);
    check("R8 regrow", key, 4'b0110);

    // R3/R4/R9 sweep: every ordered pair of patterns under both caps
    for (int d = 0; d < 2; d++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
          step(4'(a), d[0]);
          check(d ? "R3 sweep" : "R4 sweep", key, model);
          step(4'(b), d[0]);
          check(d ? "R3 sweep" : "R4 sweep", key, model);
          if (b != 0 && key == 4'b0000) check("R9 nonempty", key, model);
          step(4'(a ^ b), d[0]);
          check(d ? "R3 sweep" : "R4 sweep", key, model);
        end

    finish_run();
  end
endmodule